// File: doc/BRIEF.md
# Sequence-coded programmable clock divider

This block divides an input clock by an integer that software writes as a short shift-register code rather than as a binary count. The code is a state of a maximal-length linear feedback shift register. Counting down to a fixed terminal state therefore needs only a few XOR gates and an equality compare, with no adder. The block produces a one-cycle enable pulse once per divided period. A clock-enable input freezes it.

One architecture covers three roles, chosen by the `KIND` parameter:

- an input pre-divider, with an 8-bit register;
- a feedback multiplier divider, with a 15-bit register;
- an output post-divider, with a 5-bit register, whose effective ratio is doubled.

The roles differ only in register width, feedback taps, seed, reserved codes and maximum ratio. Three reserved codes per role bypass the register and select ratios 0, 1 and 2. A readback engine turns a code back into its binary ratio. It starts from the seed and steps a reference register one state per clock until the state matches the code. If no state matches, it returns an all-ones marker.

Top module: `lfsr_clkdiv`

## Requirements
- R1: After reset `tick_o`, `rd_done_o` and `rd_ratio_o` are all 0.
- R2: Register step: shift right by one and insert at the top bit the XOR of the tap bits. The three roles are:
  - pre-divider: 8-bit, taps at bits 0, 2, 3 and 4, seed 0x80;
  - multiplier: 15-bit, taps at bits 0 and 1, seed 0x4000;
  - post-divider: 5-bit, taps at bits 0 and 2, seed 0x10.
  The code for ratio r (3 to 2^width) is the state reached after 2^width - r + 1 steps from the seed, with all code bits above the register width at 0. With such a code and `en_i` held high, the pre-divider pulses `tick_o` once every r clocks.
- R3: Pre-divider reserved codes: 0x3FF (ratio 0, treated as 1) and 0x302 (ratio 1) give a pulse every clock; 0x202 gives a pulse every 2 clocks.
- R4: The post-divider divides by twice its decoded ratio: an LFSR code for r gives a period of 2r. Its reserved codes are 0x7F (ratio 0, treated as 2, period 4), 0x62 (period 2) and 0x42 (period 4).
- R5: With `bypass_i` high, the pre-divider and the post-divider pulse `tick_o` on every enabled clock, whatever the code.
- R6: While `en_i` is low no `tick_o` pulse occurs. When `en_i` returns high the programmed period resumes.
- R7: The divider never pulses for a code that is neither reserved nor a valid sequence state. Such a code has a nonzero bit above the register width, or a register part that is zero or equal to the seed.
- R8: After `rd_start_i` is sampled with an LFSR code for ratio r, `rd_done_o` pulses for one cycle exactly 2^width - r + 1 clocks later, with `rd_ratio_o` = r. Reserved codes return 0, 1 or 2 one clock after the start.
- R9: For an invalid code, the readback returns all ones on `rd_ratio_o` with `rd_done_o`, 2^width - 2 clocks after the start.
- R10: `rd_start_i` is ignored while a readback search is running. The result and its timing belong to the code captured at the first start.
- R11: Multiplier readback: code 0x18003 returns 1, and codes for ratios 0x8000 and 0x7FF0 return those ratios. A code with bits 16:15 set that is not reserved returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Clock enable for the divider |
| bypass_i | input | 1 | Force ratio 1 (pre- and post-divider roles only) |
| code_i | input | CODE_W (10) | Ratio code |
| rd_start_i | input | 1 | Start a readback of `code_i` |
| tick_o | output | 1 | Divided-clock enable pulse |
| rd_done_o | output | 1 | One-cycle readback completion pulse |
| rd_ratio_o | output | RATIO_W (9) | Decoded ratio, all ones if invalid |

## Verification
The bench builds three instances at once, one with each `KIND` value.

- The pre-divider instance brings the full 3 to 256 range within reach, including both ends of the sequence, the reserved codes, bypass and the invalid seed and upper-bit codes.
- The post-divider instance exposes the doubling stage and its different meaning for ratio 0.
- The multiplier instance walks the 15-bit sequence. Readback latency is checked there on both ends, up to the full-length search for an invalid code.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  typedef enum logic [1:0] {KIND_PRE, KIND_MUL, KIND_POST} div_kind_e;
  typedef enum logic [1:0] {MODE_ONE, MODE_TWO, MODE_LFSR, MODE_STOP} div_mode_e;

  function automatic int kind_code_w(div_kind_e k);
    case (k)
      KIND_MUL:  return 17;
      KIND_POST: return 7;
      default:   return 10;
    endcase
  endfunction

  function automatic int kind_lfsr_w(div_kind_e k);
    case (k)
      KIND_MUL:  return 15;
      KIND_POST: return 5;
      default:   return 8;
    endcase
  endfunction

  function automatic int kind_seed(div_kind_e k);
    case (k)
      KIND_MUL:  return 'h4000;
      KIND_POST: return 'h10;
      default:   return 'h80;
    endcase
  endfunction

  function automatic int kind_taps(div_kind_e k);
    case (k)
      KIND_MUL:  return 'h03;
      KIND_POST: return 'h05;
      default:   return 'h1D;
    endcase
  endfunction

  function automatic int kind_res(div_kind_e k, int which);
    case (k)
      KIND_MUL:  return (which == 0) ? 'h1FFFF : (which == 1) ? 'h18003 : 'h10003;
      KIND_POST: return (which == 0) ? 'h7F : (which == 1) ? 'h62 : 'h42;
      default:   return (which == 0) ? 'h3FF : (which == 1) ? 'h302 : 'h202;
    endcase
  endfunction

  function automatic bit kind_doubles(div_kind_e k);
    return k == KIND_POST;
  endfunction

  function automatic bit kind_has_bypass(div_kind_e k);
    return k != KIND_MUL;
  endfunction

endpackage

// File: rtl/lfsr_div_mode.sv
module lfsr_div_mode
  import lfsr_div_pkg::*;
#(
  parameter div_kind_e KIND   = KIND_PRE,
  parameter int        CODE_W = kind_code_w(KIND),
  parameter int        LFSR_W = kind_lfsr_w(KIND)
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              bypass_i,
  output div_mode_e         mode_o,
  output logic              dbl_o
);
  localparam logic [CODE_W-1:0] RES0 = CODE_W'(kind_res(KIND, 0));
  localparam logic [CODE_W-1:0] RES1 = CODE_W'(kind_res(KIND, 1));
  localparam logic [CODE_W-1:0] RES2 = CODE_W'(kind_res(KIND, 2));
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(kind_seed(KIND));
  localparam bit                BYP  = kind_has_bypass(KIND);
  localparam bit                DBL  = kind_doubles(KIND);

  logic seq_ok;

  assign seq_ok = (code_i[CODE_W-1:LFSR_W] == '0) &&
                  (code_i[LFSR_W-1:0] != '0) &&
                  (code_i[LFSR_W-1:0] != SEED);

  always_comb begin
    dbl_o = DBL;
    if (BYP && bypass_i) begin
      mode_o = MODE_ONE;
      dbl_o  = 1'b0;
    end else if (code_i == RES0) begin
      mode_o = DBL ? MODE_TWO : MODE_ONE;
    end else if (code_i == RES1) begin
      mode_o = MODE_ONE;
    end else if (code_i == RES2) begin
      mode_o = MODE_TWO;
    end else if (seq_ok) begin
      mode_o = MODE_LFSR;
    end else begin
      mode_o = MODE_STOP;
    end
  end
endmodule

// File: rtl/lfsr_div_counter.sv
module lfsr_div_counter
  import lfsr_div_pkg::*;
#(
  parameter div_kind_e KIND   = KIND_PRE,
  parameter int        LFSR_W = kind_lfsr_w(KIND)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  div_mode_e         mode_i,
  input  logic              dbl_i,
  input  logic [LFSR_W-1:0] load_i,
  output logic              tick_o
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(kind_seed(KIND));
  localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(kind_taps(KIND));

  logic [LFSR_W-1:0] state;
  logic              reload;
  logic              toggle;
  logic              phase;
  logic              beat;

  assign beat = en_i && (phase || !dbl_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEED;
      reload <= 1'b1;
      toggle <= 1'b0;
      phase  <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (en_i && dbl_i) phase <= !phase;
      if (beat) begin
        case (mode_i)
          MODE_ONE: begin
            tick_o <= 1'b1;
            reload <= 1'b1;
          end
          MODE_TWO: begin
            toggle <= !toggle;
            tick_o <= toggle;
            reload <= 1'b1;
          end
          MODE_LFSR: begin
            if (reload) begin
              state  <= load_i;
              reload <= 1'b0;
            end else if (state == SEED) begin
              reload <= 1'b1;
              tick_o <= 1'b1;
            end else begin
              state <= {^(state & TAPS), state[LFSR_W-1:1]};
            end
          end
          default: reload <= 1'b1;
        endcase
      end
    end
  end

  // R2: the running register never falls into the all-zero lock-up state
  p_state_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    state != '0);
  // R6: a clock without enable produces no pulse on the next cycle
  p_idle_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(en_i) |-> !tick_o);
  // R7: an unusable code never yields a pulse
  p_stop_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
    $past(mode_i == MODE_STOP) |-> !tick_o);
endmodule

// File: rtl/lfsr_div_readback.sv
module lfsr_div_readback
  import lfsr_div_pkg::*;
#(
  parameter div_kind_e KIND    = KIND_PRE,
  parameter int        CODE_W  = kind_code_w(KIND),
  parameter int        LFSR_W  = kind_lfsr_w(KIND),
  parameter int        RATIO_W = LFSR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               done_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam logic [CODE_W-1:0]  RES0  = CODE_W'(kind_res(KIND, 0));
  localparam logic [CODE_W-1:0]  RES1  = CODE_W'(kind_res(KIND, 1));
  localparam logic [CODE_W-1:0]  RES2  = CODE_W'(kind_res(KIND, 2));
  localparam logic [LFSR_W-1:0]  SEED  = LFSR_W'(kind_seed(KIND));
  localparam logic [LFSR_W-1:0]  TAPS  = LFSR_W'(kind_taps(KIND));
  localparam logic [RATIO_W-1:0] TOP   = RATIO_W'(1) << LFSR_W;
  localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(3);

  logic               busy;
  logic [CODE_W-1:0]  held;
  logic [LFSR_W-1:0]  walk;
  logic [LFSR_W-1:0]  walk_nxt;
  logic [RATIO_W-1:0] idx;

  assign walk_nxt = {^(walk & TAPS), walk[LFSR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      held    <= '0;
      walk    <= SEED;
      idx     <= TOP;
      done_o  <= 1'b0;
      ratio_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1;
          held <= code_i;
          walk <= SEED;
          idx  <= TOP;
        end
      end else if (held == RES0 || held == RES1 || held == RES2) begin
        busy    <= 1'b0;
        done_o  <= 1'b1;
        ratio_o <= (held == RES0) ? RATIO_W'(0) : (held == RES1) ? RATIO_W'(1) : RATIO_W'(2);
      end else if (held[CODE_W-1:LFSR_W] == '0 && walk_nxt == held[LFSR_W-1:0]) begin
        busy    <= 1'b0;
        done_o  <= 1'b1;
        ratio_o <= idx;
      end else if (idx == FLOOR) begin
        busy    <= 1'b0;
        done_o  <= 1'b1;
        ratio_o <= '1;
      end else begin
        walk <= walk_nxt;
        idx  <= idx - 1'b1;
      end
    end
  end

  // R8: completion is a single-cycle pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: the reference register stays inside the maximal sequence
  p_walk_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> walk != '0);
  // R9: a result is either a legal ratio or the all-ones marker
  p_ratio_range_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ratio_o == '1 || ratio_o <= TOP));
  // R10: a start during a search does not replace the captured code
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start_i) |=> $stable(held));
endmodule

// File: rtl/lfsr_clkdiv.sv
module lfsr_clkdiv
  import lfsr_div_pkg::*;
#(
  parameter div_kind_e KIND    = KIND_PRE,
  parameter int        CODE_W  = kind_code_w(KIND),
  parameter int        LFSR_W  = kind_lfsr_w(KIND),
  parameter int        RATIO_W = LFSR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               bypass_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               rd_start_i,
  output logic               tick_o,
  output logic               rd_done_o,
  output logic [RATIO_W-1:0] rd_ratio_o
);
  div_mode_e mode;
  logic      dbl;

  lfsr_div_mode #(.KIND(KIND), .CODE_W(CODE_W), .LFSR_W(LFSR_W)) u_mode (
    .code_i   (code_i),
    .bypass_i (bypass_i),
    .mode_o   (mode),
    .dbl_o    (dbl)
  );

  lfsr_div_counter #(.KIND(KIND), .LFSR_W(LFSR_W)) u_count (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .mode_i (mode),
    .dbl_i  (dbl),
    .load_i (code_i[LFSR_W-1:0]),
    .tick_o (tick_o)
  );

  lfsr_div_readback #(.KIND(KIND), .CODE_W(CODE_W), .LFSR_W(LFSR_W), .RATIO_W(RATIO_W)) u_read (
    .clk     (clk),
    .rst     (rst),
    .start_i (rd_start_i),
    .code_i  (code_i),
    .done_o  (rd_done_o),
    .ratio_o (rd_ratio_o)
  );
endmodule

// File: tb/test_lfsr_clkdiv.sv
`timescale 1ns/1ps
module test_lfsr_clkdiv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic byp = 1'b0;
  logic [9:0]  code_pre  = 10'h3FF;
  logic [6:0]  code_post = 7'h7F;
  logic [16:0] code_mul  = 17'h1FFFF;
  logic st_pre = 1'b0, st_post = 1'b0, st_mul = 1'b0;
  logic t_pre, t_post, t_mul;
  logic d_pre, d_post, d_mul;
  logic [8:0]  r_pre;
  logic [5:0]  r_post;
  logic [15:0] r_mul;
  int n_tests = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lfsr_clkdiv i_lfsr_clkdiv (
    .clk(clk), .rst(rst), .en_i(en), .bypass_i(byp), .code_i(code_pre),
    .rd_start_i(st_pre), .tick_o(t_pre), .rd_done_o(d_pre), .rd_ratio_o(r_pre));

  lfsr_clkdiv #(.KIND(lfsr_div_pkg::KIND_POST)) i_post (
    .clk(clk), .rst(rst), .en_i(en), .bypass_i(byp), .code_i(code_post),
    .rd_start_i(st_post), .tick_o(t_post), .rd_done_o(d_post), .rd_ratio_o(r_post));

  lfsr_clkdiv #(.KIND(lfsr_div_pkg::KIND_MUL)) i_mul (
    .clk(clk), .rst(rst), .en_i(en), .bypass_i(byp), .code_i(code_mul),
    .rd_start_i(st_mul), .tick_o(t_mul), .rd_done_o(d_mul), .rd_ratio_o(r_mul));

  // expected code: state after 2^w - r + 1 steps from the seed
  function automatic int seq_code(int w, int taps, int seed, int r);
    int x = seed;
    for (int k = 0; k < (1 << w) - r + 1; k++) begin
      int fb = 0;
      for (int b = 0; b < w; b++) if (taps[b]) fb ^= (x >> b) & 1;
      x = (fb << (w - 1)) | (x >> 1);
    end
    return x;
  endfunction

  function automatic int pre_code(int r);  return seq_code(8, 'h1D, 'h80, r);     endfunction
  function automatic int post_code(int r); return seq_code(5, 'h05, 'h10, r);     endfunction
  function automatic int mul_code(int r);  return seq_code(15, 'h03, 'h4000, r);  endfunction

  function automatic bit tk(int w);
    return (w == 0) ? t_pre : (w == 1) ? t_post : t_mul;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(int w, output int cyc, output bit ok);
    cyc = 0;
    ok = 1'b0;
    while (!ok && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (tk(w)) ok = 1'b1;
    end
  endtask

  task automatic check_period(int w, int exp, string tag);
    int c;
    bit ok1, ok2, ok3;
    wait_tick(w, c, ok1);
    wait_tick(w, c, ok2);
    wait_tick(w, c, ok3);
    if (!(ok1 && ok2 && ok3)) c = -1;
    chk(c == exp, tag, c, exp);
  endtask

  task automatic check_silent(int w, string tag);
    int cnt = 0;
    repeat (600) begin
      @(negedge clk);
      if (tk(w)) cnt++;
    end
    chk(cnt == 0, tag, cnt, 0);
  endtask

  task automatic rb(int w, int code, int exp_r, int exp_lat, string tag, bit inject);
    int n = 0;
    bit got = 1'b0;
    int act;
    @(negedge clk);
    if (w == 0) begin code_pre = 10'(code); st_pre = 1'b1; end
    else if (w == 1) begin code_post = 7'(code); st_post = 1'b1; end
    else begin code_mul = 17'(code); st_mul = 1'b1; end
    @(negedge clk);
    st_pre = 1'b0; st_post = 1'b0; st_mul = 1'b0;
    while (!got && n < 40000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (inject && n == 3) begin code_pre = 10'h202; st_pre = 1'b1; end
      if (inject && n == 4) begin code_pre = 10'(code); st_pre = 1'b0; end
      if (w == 0 && d_pre) got = 1'b1;
      if (w == 1 && d_post) got = 1'b1;
      if (w == 2 && d_mul) got = 1'b1;
    end
    act = (w == 0) ? int'(r_pre) : (w == 1) ? int'(r_post) : int'(r_mul);
    if (!got) act = -1;
    chk(act == exp_r, {tag, " ratio"}, act, exp_r);
    chk(n == exp_lat, {tag, " latency"}, n, exp_lat);
  endtask

  initial begin
    #950000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(t_pre == 1'b0 && t_post == 1'b0, "R1 tick", int'(t_pre), 0);
    chk(d_pre == 1'b0 && d_mul == 1'b0, "R1 done", int'(d_pre), 0);
    chk(r_pre == 0 && r_mul == 0, "R1 ratio", int'(r_pre), 0);

    en = 1'b1;
    // R2 sequence codes on the pre-divider: ends and random ratios
    code_pre = 10'(pre_code(3));   check_period(0, 3, "R2 ratio 3");
    code_pre = 10'(pre_code(256)); check_period(0, 256, "R2 ratio 256");
    repeat (4) begin
      r = 3 + int'($urandom % 254);
      code_pre = 10'(pre_code(r));
      check_period(0, r, $sformatf("R2 ratio %0d", r));
    end
    // R3 reserved pre-divider codes
    code_pre = 10'h3FF; check_period(0, 1, "R3 code 0x3FF");
    code_pre = 10'h302; check_period(0, 1, "R3 code 0x302");
    code_pre = 10'h202; check_period(0, 2, "R3 code 0x202");
    // R4 post-divider doubles
    code_post = 7'h7F; check_period(1, 4, "R4 code 0x7F");
    code_post = 7'h62; check_period(1, 2, "R4 code 0x62");
    code_post = 7'h42; check_period(1, 4, "R4 code 0x42");
    code_post = 7'(post_code(32)); check_period(1, 64, "R4 ratio 32");
    repeat (3) begin
      r = 3 + int'($urandom % 30);
      code_post = 7'(post_code(r));
      check_period(1, 2 * r, $sformatf("R4 ratio %0d", r));
    end
    // R5 bypass
    byp = 1'b1;
    code_pre = 10'(pre_code(50));
    check_period(0, 1, "R5 pre bypass");
    check_period(1, 1, "R5 post bypass");
    byp = 1'b0;
    // R6 enable low freezes, then period resumes
    code_pre = 10'(pre_code(20));
    check_period(0, 20, "R6 before pause");
    @(negedge clk);
    en = 1'b0;
    begin
      int cnt = 0;
      repeat (100) begin
        @(negedge clk);
        if (t_pre || t_post) cnt++;
      end
      chk(cnt == 0, "R6 no tick while disabled", cnt, 0);
    end
    en = 1'b1;
    check_period(0, 20, "R6 after pause");
    // R7 invalid codes stay silent
    code_pre = 10'h080; check_silent(0, "R7 seed code");
    code_pre = 10'h155; check_silent(0, "R7 upper bits set");
    code_pre = 10'h000; check_silent(0, "R7 zero code");
    // R8 readback of sequence and reserved codes
    rb(0, pre_code(256), 256, 1, "R8 pre 256", 1'b0);
    rb(0, pre_code(3), 3, 254, "R8 pre 3", 1'b0);
    repeat (3) begin
      r = 3 + int'($urandom % 254);
      rb(0, pre_code(r), r, 257 - r, $sformatf("R8 pre %0d", r), 1'b0);
    end
    rb(0, 'h3FF, 0, 1, "R8 pre 0x3FF", 1'b0);
    rb(0, 'h202, 2, 1, "R8 pre 0x202", 1'b0);
    rb(1, post_code(7), 7, 26, "R8 post 7", 1'b0);
    // R9 invalid readback
    rb(0, 'h080, 511, 254, "R9 pre seed", 1'b0);
    rb(1, 'h25, 63, 30, "R9 post upper bits", 1'b0);
    // R10 restart during a search is ignored
    rb(0, pre_code(10), 10, 247, "R10 restart", 1'b1);
    // R11 multiplier readback
    rb(2, 'h18003, 1, 1, "R11 mul 0x18003", 1'b0);
    rb(2, mul_code(32768), 32768, 1, "R11 mul 32768", 1'b0);
    rb(2, mul_code(32752), 32752, 17, "R11 mul 32752", 1'b0);
    rb(2, 'h1FFFE, 65535, 32766, "R11 mul invalid", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule